// File: doc/BRIEF.md
# Immediate Word Load/Store Unit

This block carries out the two descriptor commands that move a small immediate value between system memory and the 32-bit command-dependent word of a DMA descriptor. A sequencer that has already fetched the descriptor pulses `start` with the command direction, the address-space key, the raw request count, the target address and the current command-dependent word. The unit decodes the access size from the count, forces the address onto that size's boundary, checks the key, and then issues one read or write on a valid/ready memory request port.

A load places the bytes it reads at the top of the command-dependent word and keeps the remaining low bits of the old word. A store sends the top bytes of the word, right-justified in the write data. When the memory response arrives the unit presents the updated word and a one-cycle `done` pulse. The `commit` flag tells the sequencer whether to do the usual completion work (write the status back, clear the flush flag, apply the interrupt rule and step to the next descriptor in sequence, never branching) or to stay parked because its wait condition held. An illegal key produces a one-cycle `kill` pulse instead of any memory traffic.

Top module: `word_xfer_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `mem_req_valid`, `done`, `commit` and `kill` are all 0.
- R2: The access size is decided from count bits 2:0 only, by priority: bit 2 set gives 4 bytes (size code 2), else bit 1 set gives 2 bytes (size code 1), else 1 byte (size code 0). Count bits above bit 2 have no effect.
- R3: The request address has bits 1:0 cleared for a 4-byte access, bit 0 cleared for a 2-byte access, and is passed unchanged for a 1-byte access.
- R4: A load returns in `word_out` the full read word for 4 bytes, read bits 15:0 in bits 31:16 above the old bits 15:0 for 2 bytes, and read bits 7:0 in bits 31:24 above the old bits 23:0 for 1 byte.
- R5: A store raises `mem_req_write` and drives write data equal to the whole word for 4 bytes, old bits 31:16 in bits 15:0 (zero above) for 2 bytes, and old bits 31:24 in bits 7:0 (zero above) for 1 byte; `word_out` then equals the unchanged input word.
- R6: Key codes 5 (register space) and 7 (device space) are refused: `kill` pulses for exactly one cycle, in the cycle after `start`, no memory request is made and the unit returns to idle.
- R7: Key codes 0 to 4 are handled as the system key (code 6) and the access proceeds normally.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, size, direction and data do not change.
- R9: `done` is a one-cycle pulse in the cycle after the response is accepted and never before it; `commit` is high with `done` when `hold_cond` was low at the response and low when it was high.
- R10: A `start` while the unit is busy is ignored, and command inputs changed after acceptance do not alter the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (taken only when idle) |
| is_store | input | 1 | 1 = store word, 0 = load word |
| key | input | KEY_W | Address-space key code |
| req_count | input | CNT_W | Raw request count of the descriptor |
| addr | input | ADDR_W | Memory address from the descriptor |
| cmd_dep | input | 32 | Current command-dependent word |
| hold_cond | input | 1 | Wait condition from the sequencer, sampled at the response |
| busy | output | 1 | A command is in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write |
| mem_req_size | output | 2 | Log2 of the byte count |
| mem_req_addr | output | ADDR_W | Aligned request address |
| mem_req_wdata | output | 32 | Right-justified write data |
| mem_rsp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Right-justified read data |
| word_out | output | 32 | Updated command-dependent word, valid with `done` |
| done | output | 1 | Command finished |
| commit | output | 1 | With `done`: perform completion and sequential advance |
| kill | output | 1 | Illegal key, the channel must be stopped |

## Verification
Loads and stores are run with counts whose low bits are 1, 2, 3, 4 and 7 and with counts carrying only high bits, so a decoder that ignores the priority or reads the wrong bits gives a different size. Unaligned addresses ending in 1 and 3 separate the alignment cases, and old words and read data with distinct byte patterns show whether partial loads merge at the top or zero-extend and whether stores take the top bytes. Keys 5 and 7 against keys 2 and 6 tell the kill path from the remapping of low keys; a stalled ready, a set wait condition, and a second start with altered inputs during a busy command cover the handshake, the commit flag and the ignore rule.

// File: rtl/wxu_pkg.sv
`timescale 1ns/1ps
package wxu_pkg;

  localparam int DW = 32;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2
  } xsize_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_KILL = 3'd1,
    ST_REQ  = 3'd2,
    ST_RSP  = 3'd3,
    ST_DONE = 3'd4
  } xstate_e;

  // Priority decode of the three size bits of the count.
  function automatic xsize_e size_of(input logic [2:0] cnt);
    xsize_e s;
    casez (cnt)
      3'b1??:  s = SZ_B4;
      3'b01?:  s = SZ_B2;
      default: s = SZ_B1;
    endcase
    return s;
  endfunction

  // New value of the two lowest address bits after alignment.
  function automatic logic [1:0] low_bits(input xsize_e s, input logic [1:0] lo);
    logic [1:0] r;
    case (s)
      SZ_B4:   r = 2'b00;
      SZ_B2:   r = {lo[1], 1'b0};
      default: r = lo;
    endcase
    return r;
  endfunction

  // Store data: top bytes of the word, right-justified.
  function automatic logic [DW-1:0] store_data(input xsize_e s, input logic [DW-1:0] w);
    logic [DW-1:0] r;
    case (s)
      SZ_B4:   r = w;
      SZ_B2:   r = {{(DW/2){1'b0}}, w[DW-1:DW/2]};
      default: r = {{(DW-8){1'b0}}, w[DW-1:DW-8]};
    endcase
    return r;
  endfunction

  // Load merge: read bytes go to the top, old low bits stay.
  function automatic logic [DW-1:0] load_merge(input xsize_e s, input logic [DW-1:0] w,
                                               input logic [DW-1:0] rd);
    logic [DW-1:0] r;
    case (s)
      SZ_B4:   r = rd;
      SZ_B2:   r = {rd[DW/2-1:0], w[DW/2-1:0]};
      default: r = {rd[7:0], w[DW-9:0]};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wxu_decode.sv
`timescale 1ns/1ps
module wxu_decode
  import wxu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int KEY_W    = 3,
  parameter int KEY_REGS = 5,
  parameter int KEY_SYS  = 6
) (
  input  logic [KEY_W-1:0]  key,
  input  logic [2:0]        cnt_lo,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dep,
  output xsize_e            size,
  output logic [ADDR_W-1:0] addr_al,
  output logic [DW-1:0]     wdata,
  output logic              key_ok
);

  localparam logic [KEY_W-1:0] K_REGS = KEY_W'(KEY_REGS);
  localparam logic [KEY_W-1:0] K_SYS  = KEY_W'(KEY_SYS);

  logic [KEY_W-1:0] key_eff;

  always_comb begin
    size    = size_of(cnt_lo);
    addr_al = {addr[ADDR_W-1:2], low_bits(size, addr[1:0])};
    wdata   = store_data(size, dep);
    key_eff = (key < K_REGS) ? K_SYS : key;
    key_ok  = (key_eff == K_SYS);
  end

endmodule

// File: rtl/wxu_merge.sv
`timescale 1ns/1ps
module wxu_merge
  import wxu_pkg::*;
(
  input  xsize_e        size,
  input  logic          is_store,
  input  logic [DW-1:0] dep,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] word_new
);

  always_comb begin
    if (is_store) word_new = dep;
    else          word_new = load_merge(size, dep, rdata);
  end

endmodule

// File: rtl/wxu_ctrl.sv
`timescale 1ns/1ps
module wxu_ctrl
  import wxu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic key_ok,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic accept,
  output logic take_rsp,
  output logic req_valid,
  output logic busy,
  output logic kill,
  output logic done
);

  xstate_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= key_ok ? ST_REQ : ST_KILL;
        ST_KILL: state <= ST_IDLE;
        ST_REQ:  if (req_ready) state <= ST_RSP;
        ST_RSP:  if (rsp_valid) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    accept    = (state == ST_IDLE) && start;
    take_rsp  = (state == ST_RSP) && rsp_valid;
    req_valid = (state == ST_REQ);
    busy      = (state != ST_IDLE);
    kill      = (state == ST_KILL);
    done      = (state == ST_DONE);
  end

endmodule

// File: rtl/word_xfer_unit.sv
`timescale 1ns/1ps
module word_xfer_unit
  import wxu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int KEY_W    = 3,
  parameter int KEY_REGS = 5,
  parameter int KEY_SYS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_store,
  input  logic [KEY_W-1:0]  key,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       cmd_dep,
  input  logic              hold_cond,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [1:0]        mem_req_size,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic [31:0]       word_out,
  output logic              done,
  output logic              commit,
  output logic              kill
);

  // Named internal events (also observed by the checker).
  logic start_take;
  logic rsp_take;

  xsize_e            dec_size;
  logic [ADDR_W-1:0] dec_addr;
  logic [DW-1:0]     dec_wdata;
  logic              dec_key_ok;

  logic              unused_cnt_hi;
  assign unused_cnt_hi = ^req_count[CNT_W-1:3];

  wxu_decode #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY_REGS(KEY_REGS), .KEY_SYS(KEY_SYS)
  ) u_dec (
    .key(key), .cnt_lo(req_count[2:0]), .addr(addr), .dep(cmd_dep),
    .size(dec_size), .addr_al(dec_addr), .wdata(dec_wdata), .key_ok(dec_key_ok)
  );

  wxu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .key_ok(dec_key_ok),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid),
    .accept(start_take), .take_rsp(rsp_take), .req_valid(mem_req_valid),
    .busy(busy), .kill(kill), .done(done)
  );

  // Command held for the whole access.
  logic              op_store_q;
  xsize_e            size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     dep_q;
  logic [DW-1:0]     word_q;
  logic              commit_q;
  logic [DW-1:0]     merged;

  wxu_merge u_merge (
    .size(size_q), .is_store(op_store_q), .dep(dep_q),
    .rdata(mem_rsp_rdata), .word_new(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_store_q <= 1'b0;
      size_q     <= SZ_B1;
      addr_q     <= '0;
      wdata_q    <= '0;
      dep_q      <= '0;
    end else if (start_take) begin
      op_store_q <= is_store;
      size_q     <= dec_size;
      addr_q     <= dec_addr;
      wdata_q    <= dec_wdata;
      dep_q      <= cmd_dep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      commit_q <= 1'b0;
    end else if (rsp_take) begin
      word_q   <= merged;
      commit_q <= !hold_cond;
    end
  end

  assign mem_req_write = op_store_q;
  assign mem_req_size  = size_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign word_out      = word_q;
  assign commit        = done && commit_q;

endmodule

// File: rtl/word_xfer_unit_chk.sv
`timescale 1ns/1ps
module word_xfer_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [1:0]        mem_req_size,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              done,
  input logic              kill,
  input logic              rsp_take
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_size) && $stable(mem_req_write) && $stable(mem_req_wdata)); // R8

  AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_size != 2'd3); // R2

  AST_ALIGN_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_size == 2'd2 |-> mem_req_addr[1:0] == 2'b00); // R3

  AST_ALIGN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_size == 2'd1 |-> mem_req_addr[0] == 1'b0); // R3

  AST_KILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !mem_req_valid && !done); // R6

  AST_KILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !kill); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rsp_take)); // R9

endmodule

bind word_xfer_unit word_xfer_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_size(mem_req_size), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .done(done), .kill(kill), .rsp_take(rsp_take)
);

// File: tb/tb_word_xfer_unit.sv
`timescale 1ns/1ps
module tb_word_xfer_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_store = 1'b0;
  logic [2:0]  key = 3'd6;
  logic [15:0] req_count = '0;
  logic [31:0] addr = '0;
  logic [31:0] cmd_dep = '0;
  logic        hold_cond = 1'b0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [1:0]  mem_req_size;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic [31:0] word_out;
  logic        done;
  logic        commit;
  logic        kill;

  always #4 clk = ~clk;

  word_xfer_unit dut (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog R1..: cycles=%0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", what, got, exp);
    end
  endtask

  // Independent expectations.
  function automatic int nbytes(input logic [15:0] c);
    if (c[2]) return 4;
    if (c[1]) return 2;
    return 1;
  endfunction
  function automatic logic [31:0] szcode(input int n);
    return (n == 4) ? 32'd2 : (n == 2) ? 32'd1 : 32'd0;
  endfunction
  function automatic logic [31:0] exp_addr(input int n, input logic [31:0] a);
    return a & ~(n - 1);
  endfunction
  function automatic logic [31:0] exp_load(input int n, input logic [31:0] d, input logic [31:0] rd);
    if (n == 4) return rd;
    if (n == 2) return (rd << 16) | (d & 32'h0000_FFFF);
    return (rd << 24) | (d & 32'h00FF_FFFF);
  endfunction
  function automatic logic [31:0] exp_store(input int n, input logic [31:0] d);
    if (n == 4) return d;
    return d >> (32 - 8 * n);
  endfunction

  // Results of one command.
  logic        r_kill, r_req, r_stable, r_done_early, r_done, r_commit, r_done_after, r_busy_after;
  logic        r_write, r_kill_after;
  logic [1:0]  r_size;
  logic [31:0] r_addr, r_wdata, r_word;

  task automatic run_cmd(input logic st, input logic [2:0] k, input logic [15:0] cnt,
                         input logic [31:0] a, input logic [31:0] dep, input logic [31:0] rd,
                         input logic hold, input int stall, input logic poke);
    int waited;
    r_kill = 0; r_req = 0; r_stable = 1; r_done_early = 0; r_done = 0; r_commit = 0;
    r_done_after = 0; r_busy_after = 0; r_kill_after = 0;
    @(negedge clk);
    start = 1; is_store = st; key = k; req_count = cnt; addr = a; cmd_dep = dep; hold_cond = hold;
    @(negedge clk);
    if (poke) begin addr = 32'hFFFF_FFF0; cmd_dep = ~dep; req_count = 16'h0004; end
    else start = 0;
    if (kill) begin
      r_kill = 1;
      r_req = mem_req_valid;
      @(negedge clk);
      r_kill_after = kill; r_busy_after = busy;
      return;
    end
    waited = 0;
    while (!mem_req_valid && waited < 20) begin @(negedge clk); waited++; end
    if (!mem_req_valid) begin start = 0; return; end
    r_req = 1; r_addr = mem_req_addr; r_size = mem_req_size;
    r_write = mem_req_write; r_wdata = mem_req_wdata;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      if (!mem_req_valid || mem_req_addr !== r_addr || mem_req_size !== r_size ||
          mem_req_wdata !== r_wdata || mem_req_write !== r_write) r_stable = 0;
    end
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0; start = 0; hold_cond = hold;
    mem_rsp_valid = 1; mem_rsp_rdata = rd; r_done_early = done;
    @(negedge clk);
    mem_rsp_valid = 0; hold_cond = 0;
    r_done = done; r_word = word_out; r_commit = commit;
    @(negedge clk);
    r_done_after = done; r_busy_after = busy;
  endtask

  task automatic t_load(input string tag, input logic [15:0] cnt, input logic [31:0] a,
                        input logic [31:0] dep, input logic [31:0] rd);
    int n = nbytes(cnt);
    run_cmd(1'b0, 3'd6, cnt, a, dep, rd, 1'b0, 0, 1'b0);
    chk({tag, " R2 size"}, {30'd0, r_size}, szcode(n));
    chk({tag, " R3 addr"}, r_addr, exp_addr(n, a));
    chk({tag, " R5 read dir"}, {31'd0, r_write}, 32'd0);
    chk({tag, " R4 word"}, r_word, exp_load(n, dep, rd));
    chk({tag, " R9 done/commit"}, {30'd0, r_done, r_commit}, 32'd3);
  endtask

  task automatic t_store(input string tag, input logic [15:0] cnt, input logic [31:0] a,
                         input logic [31:0] dep);
    int n = nbytes(cnt);
    run_cmd(1'b1, 3'd6, cnt, a, dep, 32'h5A5A_5A5A, 1'b0, 0, 1'b0);
    chk({tag, " R5 write"}, {31'd0, r_write}, 32'd1);
    chk({tag, " R5 wdata"}, r_wdata, exp_store(n, dep));
    chk({tag, " R3 addr"}, r_addr, exp_addr(n, a));
    chk({tag, " R5 word unchanged"}, r_word, dep);
  endtask

  task automatic t_reset;
    chk("R1 idle outputs", {27'd0, busy, mem_req_valid, done, commit, kill}, 32'd0);
  endtask

  task automatic t_kill(input logic [2:0] k);
    run_cmd(1'b0, k, 16'h0004, 32'h4000, 32'h0, 32'h0, 1'b0, 0, 1'b0);
    chk("R6 kill pulse", {31'd0, r_kill}, 32'd1);
    chk("R6 no request", {31'd0, r_req}, 32'd0);
    chk("R6 kill one cycle / idle", {30'd0, r_kill_after, r_busy_after}, 32'd0);
  endtask

  task automatic t_low_key;
    run_cmd(1'b0, 3'd2, 16'h0004, 32'h5000, 32'h0, 32'hCAFE_F00D, 1'b0, 0, 1'b0);
    chk("R7 low key proceeds", {30'd0, r_kill, r_req}, 32'd1);
    chk("R7 low key word", r_word, 32'hCAFE_F00D);
  endtask

  task automatic t_stall;
    run_cmd(1'b1, 3'd6, 16'h0002, 32'h6003, 32'hBEEF_1234, 32'h0, 1'b0, 4, 1'b0);
    chk("R8 request held under stall", {31'd0, r_stable}, 32'd1);
    chk("R8 stalled addr", r_addr, 32'h6002);
    chk("R9 no early done", {31'd0, r_done_early}, 32'd0);
    chk("R9 done single pulse", {30'd0, r_done, r_done_after}, 32'd2);
  endtask

  task automatic t_hold;
    run_cmd(1'b0, 3'd6, 16'h0001, 32'h7001, 32'h1122_3344, 32'h0000_00AB, 1'b1, 0, 1'b0);
    chk("R9 hold -> no commit", {30'd0, r_done, r_commit}, 32'd2);
    chk("R9 hold word still merged", r_word, 32'hAB22_3344);
  endtask

  task automatic t_busy_start;
    int extra = 0;
    run_cmd(1'b1, 3'd6, 16'h0001, 32'h8003, 32'h9A00_0000, 32'h0, 1'b0, 2, 1'b1);
    chk("R10 first access addr kept", r_addr, 32'h8003);
    chk("R10 first access data kept", r_wdata, 32'h0000_009A);
    chk("R10 first access size kept", {30'd0, r_size}, 32'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_req_valid || busy) extra++;
    end
    chk("R10 no second access", extra, 32'd0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load("load4",   16'h0004, 32'h1003, 32'h0BAD_0BAD, 32'hA1B2_C3D4);
    t_load("load7",   16'h0007, 32'h1106, 32'h0, 32'h0102_0304);
    t_load("load3",   16'h0003, 32'h2001, 32'h1122_3344, 32'hFFFF_5566);
    t_load("load2",   16'h0002, 32'h2103, 32'hAAAA_BBBB, 32'h0000_C0DE);
    t_load("load1",   16'h0001, 32'h3003, 32'h1122_3344, 32'h0000_00AB);
    t_load("loadhi",  16'hFFF8, 32'h3102, 32'h5566_7788, 32'h1234_56EE);
    t_store("store4", 16'h0004, 32'h4003, 32'hDEAD_BEEF);
    t_store("store2", 16'h0002, 32'h4101, 32'hDEAD_BEEF);
    t_store("store1", 16'h0001, 32'h4203, 32'hDEAD_BEEF);
    t_store("storehi",16'hF00A, 32'h4303, 32'h1357_9BDF);
    t_kill(3'd5);
    t_kill(3'd7);
    t_low_key();
    t_stall();
    t_hold();
    t_busy_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule